// File: doc/BRIEF.md
# SMM Memory Lock and Window Decoder

This block guards a protected region at the top of installed RAM that is meant for system-management code. A byte-wide configuration port holds three registers. The first is the control register, with the open, close, lock and global-enable bits. The second is the extended control register, with the window-enable bit and a two-bit size code. The third holds the extended window size. A byte-wide memory port carries address, enable, write strobe, data and a management-mode flag. It reaches a small RAM model that sits behind the guard.

When the global enable and the window enable are both set, any access outside management mode that falls inside the window is blocked. Reads return 0xFF and writes are dropped. Accesses below the window, and all accesses made in management mode, reach RAM as usual.

The lock bit is sticky until reset. While it is set, the open bit is held at zero and the window configuration is frozen. Capacity is counted in units of `UNIT_BYTES` bytes, and `RAM_UNITS` units are installed. The window base is the installed size minus the window size.

Top module: `smm_guard`

## Requirements
- R1: After reset the control register (address 0), the extended control register (address 1) and the extended size register (address 2) all read 0x00.
- R2: While unlocked, the open bit (bit 0 of address 0) follows each write, both set and clear.
- R3: A write with the lock bit (bit 2 of address 0) set clears the open bit in the same cycle, whatever open value that write carries.
- R4: While locked, the lock bit stays set and writes that set the open bit leave it reading 0.
- R5: While locked, writes do not change the global enable (bit 3 of address 0), the window enable (bit 0 of address 1), the size code (bits 2:1 of address 1) or the extended size (address 2, in units).
- R6: Reset clears the lock, and the open bit becomes writable again.
- R7: Size codes 0, 1 and 2 select windows of 1, 2 and 8 units. The window base is (RAM_UNITS − size) × UNIT_BYTES.
- R8: Size code 3 takes the window size from the extended size register.
- R9: The window is enforced only when the global enable and the window enable are both 1. Otherwise accesses in the window reach RAM.
- R10: With the window enforced, a non-management read inside the window returns 0xFF and a non-management write there leaves RAM unchanged.
- R11: The byte just below the window base can be written and read back normally.
- R12: Accesses in management mode reach RAM inside an enforced window.
- R13: Configuration read data and memory read data appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_addr | input | 2 | Configuration register select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register value, registered |
| mem_en | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_smm | input | 1 | Access is made in management mode |
| mem_addr | input | ADDR_W | Byte address (11 bits by default) |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Memory read data, registered |

## Verification
The bench checks that a write carrying lock and open together leaves open at zero. A design that used the old lock state would leave it at one. After locking, the bench writes every configuration field. A design that froze only the open bit would let software move or shrink the window.

For each size code, the bench probes the first byte of the window and the byte just below it. An off-by-one base would block the byte below the window or expose the first byte of it. The bench then hides a dropped write behind a later management-mode read. This catches writes that leak past the guard, and it also catches a guard that blocks management-mode accesses.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;

    localparam logic [1:0] REG_CTL = 2'd0;
    localparam logic [1:0] REG_EXT = 2'd1;
    localparam logic [1:0] REG_XSZ = 2'd2;

    localparam int CTL_OPEN  = 0;
    localparam int CTL_CLOSE = 1;
    localparam int CTL_LOCK  = 2;
    localparam int CTL_GEN   = 3;
    localparam int EXT_WEN   = 0;

    localparam logic [1:0] SZC_EXT = 2'b11;

    typedef struct packed {
        logic       open;
        logic       close;
        logic       lock;
        logic       gen;
        logic       wen;
        logic [1:0] szc;
        logic [7:0] ext;
        logic [7:0] rdata;
    } cfg_state_t;

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
    import smm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_addr,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       open_o,
    output logic       lock_o,
    output logic       gen_o,
    output logic       wen_o,
    output logic [1:0] szc_o,
    output logic [7:0] ext_o
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cfg_addr)
            REG_CTL: st_d.rdata = {4'b0, st_q.gen, st_q.lock, st_q.close, st_q.open};
            REG_EXT: st_d.rdata = {5'b0, st_q.szc, st_q.wen};
            REG_XSZ: st_d.rdata = st_q.ext;
            default: st_d.rdata = 8'h00;
        endcase
        if (cfg_we) begin
            unique case (cfg_addr)
                REG_CTL: begin
                    st_d.close = cfg_wdata[CTL_CLOSE];
                    if (!st_q.lock) st_d.gen = cfg_wdata[CTL_GEN];
                    st_d.lock = st_q.lock | cfg_wdata[CTL_LOCK];
                    st_d.open = st_d.lock ? 1'b0 : cfg_wdata[CTL_OPEN];
                end
                REG_EXT: begin
                    if (!st_q.lock) begin
                        st_d.wen = cfg_wdata[EXT_WEN];
                        st_d.szc = cfg_wdata[2:1];
                    end
                end
                REG_XSZ: begin
                    if (!st_q.lock) st_d.ext = cfg_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign open_o    = st_q.open;
    assign lock_o    = st_q.lock;
    assign gen_o     = st_q.gen;
    assign wen_o     = st_q.wen;
    assign szc_o     = st_q.szc;
    assign ext_o     = st_q.ext;

endmodule

// File: rtl/smm_window_dec.sv
module smm_window_dec
    import smm_guard_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int RAM_UNITS  = 128,
    parameter int UNIT_BYTES = 16,
    parameter int SZ_A       = 1,
    parameter int SZ_B       = 2,
    parameter int SZ_C       = 8
) (
    input  logic [1:0]        szc,
    input  logic [7:0]        ext_units,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int BW     = ADDR_W + 1;
    localparam int UNIT_LG = $clog2(UNIT_BYTES);

    logic [BW-1:0] size_u;
    logic [BW-1:0] base_b;

    always_comb begin
        unique case (szc)
            2'd0:    size_u = BW'(SZ_A);
            2'd1:    size_u = BW'(SZ_B);
            2'd2:    size_u = BW'(SZ_C);
            SZC_EXT: size_u = BW'(ext_units);
            default: size_u = BW'(SZ_A);
        endcase
        if (size_u >= BW'(RAM_UNITS)) base_b = '0;
        else                          base_b = (BW'(RAM_UNITS) - size_u) << UNIT_LG;
        hit = (size_u != '0) && ({1'b0, addr} >= base_b);
    end

endmodule

// File: rtl/smm_ram.sv
module smm_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              blk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (en && we && !blk) mem[addr] <= wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (en && !we) rd_d = blk ? 8'hFF : mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/smm_guard.sv
module smm_guard #(
    parameter int RAM_UNITS  = 128,
    parameter int UNIT_BYTES = 16,
    parameter int SZ_A       = 1,
    parameter int SZ_B       = 2,
    parameter int SZ_C       = 8,
    localparam int ADDR_W    = $clog2(RAM_UNITS * UNIT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_addr,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_en,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    output logic [7:0]        mem_rdata
);

    logic       open_st, locked, gen, wen;
    logic [1:0] szc;
    logic [7:0] ext_units;
    logic       win_hit, blocked;

    smm_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .open_o    (open_st),
        .lock_o    (locked),
        .gen_o     (gen),
        .wen_o     (wen),
        .szc_o     (szc),
        .ext_o     (ext_units)
    );

    smm_window_dec #(
        .ADDR_W     (ADDR_W),
        .RAM_UNITS  (RAM_UNITS),
        .UNIT_BYTES (UNIT_BYTES),
        .SZ_A       (SZ_A),
        .SZ_B       (SZ_B),
        .SZ_C       (SZ_C)
    ) u_dec (
        .szc       (szc),
        .ext_units (ext_units),
        .addr      (mem_addr),
        .hit       (win_hit)
    );

    assign blocked = gen && wen && win_hit && !mem_smm;

    smm_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mem_en),
        .we    (mem_we),
        .blk   (blocked),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/smm_guard_chk.sv
module smm_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       locked,
    input logic       open_st,
    input logic       gen,
    input logic       wen,
    input logic [1:0] szc,
    input logic [7:0] ext_units,
    input logic       mem_en,
    input logic       mem_we,
    input logic       mem_smm,
    input logic       win_hit,
    input logic [7:0] mem_rdata
);

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    p_open_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !open_st);

    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({gen, wen, szc, ext_units}));

    p_block_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && !mem_smm && gen && wen && win_hit) |=> (mem_rdata == 8'hFF));

endmodule

bind smm_guard smm_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .open_st   (open_st),
    .gen       (gen),
    .wen       (wen),
    .szc       (szc),
    .ext_units (ext_units),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_smm   (mem_smm),
    .win_hit   (win_hit),
    .mem_rdata (mem_rdata)
);

// File: tb/test_smm_guard.sv
module test_smm_guard;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          mem_en = 1'b0;
    logic          mem_we = 1'b0;
    logic          mem_smm = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;

    int checks = 0;
    int errors = 0;

    logic       cfg_look = 1'b0;
    logic       cvld = 1'b0, mvld = 1'b0;
    logic [7:0] cq_exp[$];
    string      cq_tag[$];
    logic [7:0] mq_exp[$];
    string      mq_tag[$];

    always #4 clk = ~clk;

    smm_guard i_smm_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_smm(mem_smm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cvld <= cfg_look;
        mvld <= mem_en && !mem_we;
    end

    always @(negedge clk) begin
        if (cvld && cq_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = cq_exp.pop_front();
            t = cq_tag.pop_front();
            checks++;
            if (cfg_rdata !== e) begin
                errors++;
                $display("FAIL %s cfg read: actual %02h expected %02h", t, cfg_rdata, e);
            end
        end
        if (mvld && mq_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = mq_exp.pop_front();
            t = mq_tag.pop_front();
            checks++;
            if (mem_rdata !== e) begin
                errors++;
                $display("FAIL %s mem read: actual %02h expected %02h", t, mem_rdata, e);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        cfg_we = 1'b0; cfg_look = 1'b0; mem_en = 1'b0; mem_we = 1'b0;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d; cfg_look = 1'b0; mem_en = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        cfg_addr = a; cfg_we = 1'b0; cfg_look = 1'b1; mem_en = 1'b0;
        cq_exp.push_back(e); cq_tag.push_back(t);
    endtask

    task automatic mem_wr(input int a, input logic [7:0] d, input logic smm);
        @(negedge clk);
        cfg_we = 1'b0; cfg_look = 1'b0;
        mem_en = 1'b1; mem_we = 1'b1; mem_smm = smm; mem_addr = AW'(a); mem_wdata = d;
    endtask

    task automatic mem_rd(input int a, input logic smm, input logic [7:0] e, input string t);
        @(negedge clk);
        cfg_we = 1'b0; cfg_look = 1'b0;
        mem_en = 1'b1; mem_we = 1'b0; mem_smm = smm; mem_addr = AW'(a);
        mq_exp.push_back(e); mq_tag.push_back(t);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Configure, lock, then probe the window edges for one size choice.
    task automatic run_case(input logic [1:0] code, input logic [7:0] ext, input int base,
                            input string t);
        logic [7:0] v;
        v = 8'h30 + 8'(code);
        do_reset();
        cfg_wr(2'd2, ext);
        cfg_wr(2'd1, {5'b0, code, 1'b1});
        cfg_wr(2'd0, 8'h0A);
        cfg_wr(2'd0, 8'h0E);
        cfg_rd(2'd0, 8'h0E, "R3");
        mem_wr(base - 1, v ^ 8'h5A, 1'b0);
        mem_rd(base - 1, 1'b0, v ^ 8'h5A, "R11");
        mem_wr(base, v, 1'b1);
        mem_wr(base, 8'hC3, 1'b0);
        mem_rd(base, 1'b0, 8'hFF, t);
        mem_rd(base, 1'b0, 8'hFF, "R10");
        mem_rd(base, 1'b1, v, "R12");
        mem_rd(2047, 1'b0, 8'hFF, "R10");
        idle();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        cfg_rd(2'd0, 8'h00, "R1");
        cfg_rd(2'd1, 8'h00, "R1");
        cfg_rd(2'd2, 8'h00, "R1");
        // R2 open follows writes while unlocked
        cfg_wr(2'd0, 8'h01);
        cfg_rd(2'd0, 8'h01, "R2");
        cfg_wr(2'd0, 8'h00);
        cfg_rd(2'd0, 8'h00, "R2");
        cfg_wr(2'd0, 8'h01);
        cfg_rd(2'd0, 8'h01, "R13");
        // R3 lock with open set in the same write
        cfg_wr(2'd0, 8'h05);
        cfg_rd(2'd0, 8'h04, "R3");
        // R4 open cannot be set while locked
        cfg_wr(2'd0, 8'h01);
        cfg_rd(2'd0, 8'h04, "R4");
        cfg_wr(2'd0, 8'h05);
        cfg_rd(2'd0, 8'h04, "R4");
        // R5 frozen configuration
        cfg_wr(2'd1, 8'h07);
        cfg_rd(2'd1, 8'h00, "R5");
        cfg_wr(2'd2, 8'h20);
        cfg_rd(2'd2, 8'h00, "R5");
        cfg_wr(2'd0, 8'h0C);
        cfg_rd(2'd0, 8'h04, "R5");
        // R6 reset unlocks
        do_reset();
        cfg_rd(2'd0, 8'h00, "R6");
        cfg_wr(2'd0, 8'h01);
        cfg_rd(2'd0, 8'h01, "R6");
        idle();
        // R7 and R8 window sizes
        run_case(2'd0, 8'd0,  2032, "R7");
        run_case(2'd1, 8'd0,  2016, "R7");
        run_case(2'd2, 8'd0,  1920, "R7");
        run_case(2'd3, 8'd16, 1792, "R8");
        // R9 one enable missing: window not enforced
        do_reset();
        cfg_wr(2'd1, 8'h01);
        cfg_wr(2'd0, 8'h06);
        mem_wr(2032, 8'h44, 1'b0);
        mem_rd(2032, 1'b0, 8'h44, "R9");
        do_reset();
        cfg_wr(2'd1, 8'h00);
        cfg_wr(2'd0, 8'h0E);
        mem_wr(2040, 8'h66, 1'b0);
        mem_rd(2040, 1'b0, 8'h66, "R9");
        idle();
        idle();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule